// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. A triangular (center-aligned) carrier counts up from zero to a programmable top value and back down. Each of the three phases compares the carrier against its own active compare value. From that comparison it produces a high-side output and a low-side output. The two outputs of a phase are never high at the same time, and a programmable dead-time separates their edges.

The carrier is kept as two linked up/down counters. The primary counter sets the high-side output. A second counter runs the same path, offset upward by the dead-time count, and sets the low-side output. Because the edges of each pair come from different counters, the required gap falls out of the counting itself.

New duty values are written into per-phase buffer registers at any time. They are copied into the active compare registers only at the edge where the carrier reverses direction, at the top or at zero. When the enable input is low, the carrier is parked and all six outputs are low.

Top module: `tri_phase_cpwm`

## Requirements
- R1: While enabled, the carrier counts +1 per clock when rising and -1 per clock when falling. When it is rising and reaches a value at or above `periodIn`, the next edge turns it downward. When it is falling and reaches 0, the next edge turns it upward. `countDown` is 1 exactly while the carrier is falling.
- R2: For every phase, `pwmHi[i]` and `pwmLo[i]` are never both 1.
- R3: `pwmHi[i]` is 1 exactly when `enable` is 1 and the carrier value is strictly greater than the active compare value of phase i.
- R4: `pwmLo[i]` is 1 exactly when `enable` is 1 and the carrier value plus `deadTime` is less than or equal to the active compare value of phase i.
- R5: A clock edge with `bufWe[i]` = 1 stores `bufData` into the buffer of phase i (bit i of `bufWe` selects phase i). The write has no effect on any output until the next direction reversal.
- R6: While enabled, the active compare values change only at the clock edge where the carrier reverses direction. At that edge each one takes the buffer value held before that edge.
- R7: While `enable` is 0, all six outputs are 0. On each edge the carrier is set to 0, rising, and every active compare value is copied from its buffer.
- R8: After reset, the carrier is 0 and rising, all buffers and active compare values are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the carrier; 0 parks it and forces outputs low |
| bufWe | input | PHASES | Per-phase buffer write strobe |
| bufData | input | CNT_W | Value written into the selected buffers |
| periodIn | input | CNT_W | Carrier top value (at least 1) |
| deadTime | input | CNT_W | Offset of the low-side counter, in clocks |
| pwmHi | output | PHASES | High-side outputs |
| pwmLo | output | PHASES | Low-side outputs |
| countDown | output | 1 | 1 while the carrier is falling |

## Verification
A wrong direction bit or a missed turn shows up on `countDown` at the next clock. Within a few clocks it also shifts every pwm edge against the reference triangle. If an active compare value is loaded early or late, an edge moves in the half-cycle after the write, before the reversal that should have applied it. A drifting low-side counter shows up as a changed dead gap on the next crossing of any phase, or as a pair high together. The reference model is compared on every clock, so each of these faults is caught within one carrier period.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef struct packed {
    logic park;      // hold carrier at zero, rising
    logic goDown;    // step direction for this edge
    logic loadCmp;   // copy buffers into active compares
  } cpwmStrobes_t;
endpackage

// File: rtl/cpwm_ctrl.sv
module cpwm_ctrl
  import cpwm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         atZero,
  input  logic         atTop,
  output cpwmStrobes_t strobes,
  output logic         dirDown
);
  logic reverse;
  logic nextDown;

  always_comb begin
    reverse  = enable && (dirDown ? atZero : atTop);
    nextDown = enable ? (dirDown ^ reverse) : 1'b0;
    strobes.park    = !enable;
    strobes.goDown  = nextDown;
    strobes.loadCmp = !enable || reverse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirDown <= 1'b0;
    else       dirDown <= nextDown;
  end

  // R1: a direction change while running only follows a carrier limit
  assert_turn_at_limit_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) && !$stable(dirDown) |-> ($past(atZero) || $past(atTop)));
endmodule

// File: rtl/cpwm_datapath.sv
module cpwm_datapath
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PHASES = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enable,
  input  cpwmStrobes_t                 strobes,
  input  logic [CNT_W-1:0]             periodIn,
  input  logic [CNT_W-1:0]             deadTime,
  input  logic [PHASES-1:0]            bufWe,
  input  logic [CNT_W-1:0]             bufData,
  output logic                         atZero,
  output logic                         atTop,
  output logic [PHASES-1:0]            pwmHi,
  output logic [PHASES-1:0]            pwmLo
);
  localparam int WIDE_W = CNT_W + 1;

  logic [CNT_W-1:0]              cntMain;
  logic [WIDE_W-1:0]             cntLag;
  logic [PHASES-1:0][CNT_W-1:0]  bufReg;
  logic [PHASES-1:0][CNT_W-1:0]  cmpAct;

  assign atZero = (cntMain == '0);
  assign atTop  = (cntMain >= periodIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntMain <= '0;
      cntLag  <= '0;
    end else if (strobes.park) begin
      cntMain <= '0;
      cntLag  <= {1'b0, deadTime};
    end else if (strobes.goDown) begin
      cntMain <= cntMain - 1'b1;
      cntLag  <= cntLag - 1'b1;
    end else begin
      cntMain <= cntMain + 1'b1;
      cntLag  <= cntLag + 1'b1;
    end
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufReg[p] <= '0;
        cmpAct[p] <= '0;
      end else begin
        if (bufWe[p])        bufReg[p] <= bufData;
        if (strobes.loadCmp) cmpAct[p] <= bufReg[p];
      end
    end

    assign pwmHi[p] = enable && (cntMain > cmpAct[p]);
    assign pwmLo[p] = enable && (cntLag <= {1'b0, cmpAct[p]});

    // R2: the two gates of one leg never conduct together
    assert_pair_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(pwmHi[p] && pwmLo[p]));
  end
endmodule

// File: rtl/tri_phase_cpwm.sv
module tri_phase_cpwm
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PHASES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [PHASES-1:0] bufWe,
  input  logic [CNT_W-1:0]  bufData,
  input  logic [CNT_W-1:0]  periodIn,
  input  logic [CNT_W-1:0]  deadTime,
  output logic [PHASES-1:0] pwmHi,
  output logic [PHASES-1:0] pwmLo,
  output logic              countDown
);
  cpwmStrobes_t strobes;
  logic         atZero;
  logic         atTop;

  cpwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .atZero(atZero), .atTop(atTop),
    .strobes(strobes), .dirDown(countDown)
  );

  cpwm_datapath #(.CNT_W(CNT_W), .PHASES(PHASES)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .strobes(strobes),
    .periodIn(periodIn), .deadTime(deadTime),
    .bufWe(bufWe), .bufData(bufData),
    .atZero(atZero), .atTop(atTop),
    .pwmHi(pwmHi), .pwmLo(pwmLo)
  );

  // R6: with the carrier running and no turn, active compares hold
  assert_cmp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) && $stable(countDown) |-> $stable(u_dp.cmpAct));

  // R7: a parked carrier sits at zero and rises
  assert_parked_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (atZero && !countDown));
endmodule

// File: tb/tri_phase_cpwm_tb.sv
module tri_phase_cpwm_tb;
  localparam int CNT_W  = 16;
  localparam int PHASES = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic [PHASES-1:0] bufWe = '0;
  logic [CNT_W-1:0]  bufData = '0;
  logic [CNT_W-1:0]  periodIn = 16'd10;
  logic [CNT_W-1:0]  deadTime = 16'd2;
  logic [PHASES-1:0] pwmHi;
  logic [PHASES-1:0] pwmLo;
  logic              countDown;

  int nVec = 0;
  int nBad = 0;
  string tag = "R8";

  // reference model state
  int mCnt = 0;
  int mLag = 0;
  bit mDown = 0;
  int mBuf[PHASES];
  int mCmp[PHASES];

  tri_phase_cpwm #(.CNT_W(CNT_W), .PHASES(PHASES)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .bufWe(bufWe), .bufData(bufData),
    .periodIn(periodIn), .deadTime(deadTime),
    .pwmHi(pwmHi), .pwmLo(pwmLo), .countDown(countDown)
  );

  always #10 clk = ~clk;

  initial for (int i = 0; i < PHASES; i++) begin mBuf[i] = 0; mCmp[i] = 0; end

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mLag = 0; mDown = 0;
      for (int i = 0; i < PHASES; i++) begin mBuf[i] = 0; mCmp[i] = 0; end
    end else begin
      if (!enable) begin
        mCnt = 0; mLag = int'(deadTime); mDown = 0;
        for (int i = 0; i < PHASES; i++) mCmp[i] = mBuf[i];
      end else begin
        if (mDown ? (mCnt == 0) : (mCnt >= int'(periodIn))) begin
          mDown = !mDown;
          for (int i = 0; i < PHASES; i++) mCmp[i] = mBuf[i];
        end
        if (mDown) begin mCnt--; mLag--; end
        else       begin mCnt++; mLag++; end
      end
      for (int i = 0; i < PHASES; i++) if (bufWe[i]) mBuf[i] = int'(bufData);
    end
  end

  task automatic checkVec();
    for (int i = 0; i < PHASES; i++) begin
      bit eHi = enable && (mCnt > mCmp[i]);
      bit eLo = enable && (mLag <= mCmp[i]);
      nVec++;
      if (pwmHi[i] !== eHi) begin
        nBad++;
        $display("FAIL R3 [%s] phase %0d pwmHi actual %b expected %b", tag, i, pwmHi[i], eHi);
      end
      nVec++;
      if (pwmLo[i] !== eLo) begin
        nBad++;
        $display("FAIL R4 [%s] phase %0d pwmLo actual %b expected %b", tag, i, pwmLo[i], eLo);
      end
      nVec++;
      if (pwmHi[i] === 1'b1 && pwmLo[i] === 1'b1) begin
        nBad++;
        $display("FAIL R2 [%s] phase %0d pair actual 11 expected not both high", tag, i);
      end
    end
    nVec++;
    if (countDown !== mDown) begin
      nBad++;
      $display("FAIL R1 [%s] countDown actual %b expected %b", tag, countDown, mDown);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      checkVec();
    end
  endtask

  task automatic writeBuf(input int ph, input int val);
    bufWe = '0;
    bufWe[ph] = 1'b1;
    bufData = CNT_W'(val);
    step(1);
    bufWe = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    tag = "R8 reset";
    step(3);
    rstN = 1'b1;
    step(2);

    tag = "R7 R5 parked writes";
    writeBuf(0, 3);
    writeBuf(1, 5);
    writeBuf(2, 7);
    step(4);

    tag = "R1 R3 R4 run p10 d2";
    enable = 1'b1;
    step(45);

    tag = "R5 R6 mid-run update";
    writeBuf(0, 8);
    writeBuf(1, 1);
    writeBuf(2, 4);
    step(50);

    tag = "R7 disable mid-run";
    enable = 1'b0;
    step(5);

    tag = "R3 R4 boundary d0";
    deadTime = '0;
    writeBuf(0, 0);
    writeBuf(1, 10);
    writeBuf(2, 12);
    enable = 1'b1;
    step(50);

    tag = "R1 R4 wide dead time";
    enable = 1'b0;
    periodIn = 16'd20;
    deadTime = 16'd3;
    writeBuf(0, 20);
    writeBuf(1, 2);
    writeBuf(2, 9);
    enable = 1'b1;
    step(30);
    writeBuf(2, 15);
    step(60);

    tag = "R7 final park";
    enable = 1'b0;
    step(4);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule